// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block turns raw external pin levels into interrupt requests for a set of independent channels (two by default). Each channel has its own 2-bit sense code that picks one of three trigger styles. The styles are low level, falling edge and rising edge. The fourth code is reserved and never triggers.

Each pin first passes through a clock-domain synchronizer. Edges are then found by comparing the synchronized value with the value from the cycle before.

- **Edge modes:** a detected edge sets a sticky pending flag. The flag stays set until the CPU side sends a one-cycle acknowledge.
- **Level mode:** there is no latched state. The request follows the synchronized pin for as long as the pin is low.
- **Gating:** a channel's request reaches its output only when the global interrupt enable and that channel's mask bit are both set.

Vector dispatch and priority between channels sit outside this block.

Top module: `pin_event_sense`

## Requirements
- R1: Channel i takes its sense code from `senseMode[2*i+1:2*i]`. Each channel's code, pin, mask, acknowledge and pending state act on that channel alone.
- R2: With code 00 (low level), a gated channel's `irqReq` is high exactly while the synchronized pin is 0. It is not latched, and it drops once the high pin has been synchronized.
- R3: With code 01 (reserved), the channel never raises `irqReq` and never sets `pendFlag`, whatever the pin does.
- R4: With code 10, a 1-to-0 change of the synchronized pin sets the channel's pending flag.
- R5: With code 11, a 0-to-1 change of the synchronized pin sets the channel's pending flag. Any pin level held for at least two clocks is seen.
- R6: `irqReq[i]` is 0 whenever `globalEn` is 0 or `chanMask[i]` is 0. When both are 1 in an edge mode, `irqReq[i]` equals `pendFlag[i]`.
- R7: A pin change reaches the level request after two rising clock edges. It reaches the pending flag after three rising clock edges.
- R8: A pending flag stays set until `ackStrobe[i]` is high at a clock edge, and that edge clears it. If a new edge is detected at the same clock edge as the acknowledge, the flag stays set.
- R9: The clock edge at which a channel's sense code differs from its code at the previous edge clears that channel's pending flag. A mode change never counts as an edge.
- R10: Reset clears both pending flags, sets both synchronizers and previous samples to high, and loads the stored sense codes with 00. Edge detection is held off for the first three clock edges after reset. A pin held low through reset therefore never sets a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinRaw | input | NUM_CH | Unsynchronized external pins |
| senseMode | input | 2*NUM_CH | Sense codes, 2 bits per channel |
| globalEn | input | 1 | Global interrupt enable |
| chanMask | input | NUM_CH | Per-channel request mask |
| ackStrobe | input | NUM_CH | One-cycle pending-flag acknowledge |
| irqReq | output | NUM_CH | Gated interrupt requests |
| pendFlag | output | NUM_CH | Edge pending flags |

## Verification
The bench builds the block with the default values, NUM_CH=2 and SYNC_STAGES=2. Two channels are enough to run different sense codes side by side and to show that one channel's acknowledge or mode change leaves the other alone. The two-stage chain gives the exact two-edge and three-edge latencies that the directed checks count. Random pin toggling, mode switches, acknowledges and gating are compared every cycle with a cycle-level bench model.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic wipe;     // clear pending, suppress edge (mode change or warm-up)
    logic setPend;  // qualified edge seen this cycle
    logic clrPend;  // acknowledge
  } chan_strobe_t;

endpackage

// File: rtl/pin_event_dpath.sv
module pin_event_dpath
  import pin_event_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         pinRaw,
  input  chan_strobe_t [NUM_CH-1:0] strobes,
  output logic [NUM_CH-1:0]         syncPin,
  output logic [NUM_CH-1:0]         roseSeen,
  output logic [NUM_CH-1:0]         fellSeen,
  output logic [NUM_CH-1:0]         pendQ
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    logic [SYNC_STAGES-1:0] stageQ;
    logic                   prevQ;

    // synchronizer and previous-sample register, all reset high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stageQ <= '1;
        prevQ  <= 1'b1;
      end else begin
        stageQ <= {stageQ[SYNC_STAGES-2:0], pinRaw[gi]};
        prevQ  <= stageQ[LAST];
      end
    end

    assign syncPin[gi]  = stageQ[LAST];
    assign roseSeen[gi] = ~prevQ & stageQ[LAST];
    assign fellSeen[gi] = prevQ & ~stageQ[LAST];

    // sticky pending flag: wipe beats set, set beats acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pendQ[gi] <= 1'b0;
      else if (strobes[gi].wipe)     pendQ[gi] <= 1'b0;
      else if (strobes[gi].setPend)  pendQ[gi] <= 1'b1;
      else if (strobes[gi].clrPend)  pendQ[gi] <= 1'b0;
    end

    // R8: a qualified edge leaves the flag set even with an acknowledge
    a_r8_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes[gi].setPend && !strobes[gi].wipe) |=> pendQ[gi]);

    // R9: wipe strobe always leaves the flag clear
    a_r9_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
      strobes[gi].wipe |=> !pendQ[gi]);
  end

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*NUM_CH-1:0]       senseMode,
  input  logic                      globalEn,
  input  logic [NUM_CH-1:0]         chanMask,
  input  logic [NUM_CH-1:0]         ackStrobe,
  input  logic [NUM_CH-1:0]         syncPin,
  input  logic [NUM_CH-1:0]         roseSeen,
  input  logic [NUM_CH-1:0]         fellSeen,
  input  logic [NUM_CH-1:0]         pendQ,
  output chan_strobe_t [NUM_CH-1:0] strobes,
  output logic [NUM_CH-1:0]         irqReq
);

  // edges are held off until real pin data has filled the chain
  localparam int WARM_CYCLES = SYNC_STAGES + 1;
  localparam int CNT_W       = $clog2(WARM_CYCLES + 1);

  logic [CNT_W-1:0] warmCnt;
  logic             warmUp;

  assign warmUp = (warmCnt < CNT_W'(WARM_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      warmCnt <= '0;
    else if (warmUp) warmCnt <= warmCnt + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    sense_e modeNow;
    sense_e modeQ;
    logic   modeChg;
    logic   edgeHit;
    logic   rawReq;
    logic   gateOpen;

    assign modeNow = sense_e'(senseMode[2*gi +: 2]);
    assign modeChg = (modeNow != modeQ);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) modeQ <= SENSE_LOW;
      else        modeQ <= modeNow;
    end

    always_comb begin
      edgeHit = 1'b0;
      rawReq  = 1'b0;
      case (modeNow)
        SENSE_LOW:  rawReq = ~syncPin[gi];
        SENSE_FALL: begin edgeHit = fellSeen[gi]; rawReq = pendQ[gi]; end
        SENSE_RISE: begin edgeHit = roseSeen[gi]; rawReq = pendQ[gi]; end
        default:    begin edgeHit = 1'b0;         rawReq = 1'b0;      end
      endcase
    end

    assign gateOpen = globalEn & chanMask[gi];

    assign strobes[gi].wipe    = warmUp | modeChg;
    assign strobes[gi].setPend = edgeHit;
    assign strobes[gi].clrPend = ackStrobe[gi];
    assign irqReq[gi]          = gateOpen & rawReq;

    // R3: reserved code never asks for a pending set
    a_r3_rsvd_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (modeNow == SENSE_RSVD) |-> !strobes[gi].setPend);
  end

endmodule

// File: rtl/pin_event_sense.sv
module pin_event_sense
  import pin_event_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   pinRaw,
  input  logic [2*NUM_CH-1:0] senseMode,
  input  logic                globalEn,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic [NUM_CH-1:0]   ackStrobe,
  output logic [NUM_CH-1:0]   irqReq,
  output logic [NUM_CH-1:0]   pendFlag
);

  chan_strobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0] syncPin;
  logic [NUM_CH-1:0] roseSeen;
  logic [NUM_CH-1:0] fellSeen;
  logic [NUM_CH-1:0] pendQ;

  pin_event_dpath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinRaw   (pinRaw),
    .strobes  (strobes),
    .syncPin  (syncPin),
    .roseSeen (roseSeen),
    .fellSeen (fellSeen),
    .pendQ    (pendQ)
  );

  pin_event_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .senseMode (senseMode),
    .globalEn  (globalEn),
    .chanMask  (chanMask),
    .ackStrobe (ackStrobe),
    .syncPin   (syncPin),
    .roseSeen  (roseSeen),
    .fellSeen  (fellSeen),
    .pendQ     (pendQ),
    .strobes   (strobes),
    .irqReq    (irqReq)
  );

  assign pendFlag = pendQ;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    // R6: closed gate means no request
    a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !(globalEn && chanMask[gi]) |-> !irqReq[gi]);

    // R3: reserved code is silent at the port
    a_r3_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (senseMode[2*gi +: 2] == 2'b01) |-> !irqReq[gi]);

    // R2: low synchronized pin in level mode with open gate requests
    a_r2_level_live: assert property (@(posedge clk) disable iff (!rst_n)
      (senseMode[2*gi +: 2] == 2'b00 && globalEn && chanMask[gi] && !syncPin[gi])
        |-> irqReq[gi]);

    // R9: a changed sense code leaves the flag clear at the next edge
    a_r9_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
      (senseMode[2*gi +: 2] != $past(senseMode[2*gi +: 2])) |=> !pendFlag[gi]);

    // R8: without acknowledge or mode change the flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pendFlag[gi] && !ackStrobe[gi] &&
       senseMode[2*gi +: 2] == $past(senseMode[2*gi +: 2])) |=> pendFlag[gi]);
  end

endmodule

// File: tb/pin_event_sense_tb.sv
module pin_event_sense_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int WARM       = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] pinRaw;
  logic [2*NCH-1:0] senseMode;
  logic           globalEn;
  logic [NCH-1:0] chanMask;
  logic [NCH-1:0] ackStrobe;
  logic [NCH-1:0] irqReq;
  logic [NCH-1:0] pendFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_sense #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pinRaw(pinRaw), .senseMode(senseMode),
    .globalEn(globalEn), .chanMask(chanMask), .ackStrobe(ackStrobe),
    .irqReq(irqReq), .pendFlag(pendFlag)
  );

  // cycle-level reference model built from the requirements
  logic [NCH-1:0] mS1, mS2, mPrev, mPend;
  logic [1:0]     mMode [NCH];
  int             mWarm;

  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 = '1; mS2 = '1; mPrev = '1; mPend = '0; mWarm = 0;
      for (int c = 0; c < NCH; c++) mMode[c] = 2'b00;
    end else begin
      bit warm;
      warm = (mWarm < WARM);
      for (int c = 0; c < NCH; c++) begin
        logic [1:0] md;
        logic hit;
        md  = senseMode[2*c +: 2];
        hit = (md == 2'b10) ? (mPrev[c] & ~mS2[c]) :
              (md == 2'b11) ? (~mPrev[c] & mS2[c]) : 1'b0;
        if (warm || md != mMode[c]) mPend[c] = 1'b0;
        else if (hit)               mPend[c] = 1'b1;
        else if (ackStrobe[c])      mPend[c] = 1'b0;
        mPrev[c] = mS2[c];
        mS2[c]   = mS1[c];
        mS1[c]   = pinRaw[c];
        mMode[c] = md;
      end
      if (warm) mWarm++;
    end
  end

  function automatic logic expIrq(int c);
    logic [1:0] md;
    md = senseMode[2*c +: 2];
    if (!(globalEn && chanMask[c])) return 1'b0;
    if (md == 2'b00) return ~mS2[c];
    if (md[1])       return mPend[c];
    return 1'b0;
  endfunction

  function automatic string modeTag(int c);
    case (senseMode[2*c +: 2])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock, then compare every output against the model at mid-cycle
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/2);
    for (int c = 0; c < NCH; c++) begin
      chk(modeTag(c), $sformatf("irqReq[%0d]", c), irqReq[c], expIrq(c));
      chk("R8", $sformatf("pendFlag[%0d]", c), pendFlag[c], mPend[c]);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pinRaw = 2'b00; senseMode = 4'b11_10;
    globalEn = 1'b1; chanMask = 2'b11; ackStrobe = 2'b00;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/2);
    chk("R10", "pendFlag in reset", pendFlag[0] | pendFlag[1], 1'b0);
    chk("R10", "irqReq in reset", irqReq[0] | irqReq[1], 1'b0);
    rst_n = 1'b1;
    // r10_: pin held low through reset must not look like a falling edge
    steps(6);
    chk("R10", "no false fall after reset", pendFlag[0], 1'b0);

    // rising edge on ch1, count latency
    pinRaw = 2'b11;
    step(); chk("R7", "pend1 after 1 edge", pendFlag[1], 1'b0);
    step(); chk("R7", "pend1 after 2 edges", pendFlag[1], 1'b0);
    step(); chk("R5", "pend1 after 3 edges", pendFlag[1], 1'b1);
    // falling edge on ch0, ch1 stays pending
    pinRaw = 2'b10;
    steps(3);
    chk("R4", "pend0 on fall", pendFlag[0], 1'b1);
    chk("R8", "pend1 sticky", pendFlag[1], 1'b1);

    // acknowledge ch1 only
    ackStrobe = 2'b10; step(); ackStrobe = 2'b00;
    chk("R8", "pend1 acked", pendFlag[1], 1'b0);
    chk("R1", "pend0 untouched by ch1 ack", pendFlag[0], 1'b1);

    // new edge coincides with acknowledge
    pinRaw = 2'b00; steps(3);
    pinRaw = 2'b10; steps(2);
    ackStrobe = 2'b10; step(); ackStrobe = 2'b00;
    chk("R8", "edge wins over ack", pendFlag[1], 1'b1);

    // gating
    globalEn = 1'b0; step();
    chk("R6", "global off irq0", irqReq[0], 1'b0);
    chk("R6", "global off irq1", irqReq[1], 1'b0);
    globalEn = 1'b1; chanMask = 2'b01; step();
    chk("R6", "mask off irq1", irqReq[1], 1'b0);
    chk("R6", "mask on irq0", irqReq[0], 1'b1);
    chanMask = 2'b11;

    // mode change clears ch0
    senseMode = 4'b11_11; step();
    chk("R9", "mode change clears pend0", pendFlag[0], 1'b0);

    // level mode on ch0 (pin0 low)
    senseMode = 4'b11_00; step();
    chk("R2", "level low requests", irqReq[0], 1'b1);
    pinRaw = 2'b11; step();
    chk("R7", "level still high after 1 edge", irqReq[0], 1'b1);
    step();
    chk("R2", "level drops after pin high", irqReq[0], 1'b0);
    pinRaw = 2'b10; step();
    chk("R7", "level not yet after 1 edge", irqReq[0], 1'b0);
    step();
    chk("R2", "level back after 2 edges", irqReq[0], 1'b1);
    chk("R2", "level mode keeps pend clear", pendFlag[0], 1'b0);
    chk("R1", "ch1 pend independent", pendFlag[1], 1'b1);

    // reserved code on ch0
    senseMode = 4'b11_01;
    for (int i = 0; i < 6; i++) begin
      pinRaw[0] = ~pinRaw[0];
      steps(2);
      chk("R3", "reserved irq0", irqReq[0], 1'b0);
      chk("R3", "reserved pend0", pendFlag[0], 1'b0);
    end

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(3, 0) == 0) pinRaw[c] = ~pinRaw[c];
        if ($urandom_range(39, 0) == 0) senseMode[2*c +: 2] = 2'($urandom_range(3, 0));
        chanMask[c]  = ($urandom_range(7, 0) != 0);
        ackStrobe[c] = ($urandom_range(5, 0) == 0);
      end
      globalEn = ($urandom_range(15, 0) != 0);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule